// File: doc/BRIEF.md
# Variable-Length Instruction Bus Packer

This block sits between a source of compressed instructions and a fixed 32-bit bus. Each compressed instruction arrives with a payload and a bit count. Instead of placing each instruction alone in the low end of a bus word and leaving the top bits empty, the block lays the instructions end to end. An instruction that does not fit in what is left of the current word is split. Its low part finishes the current word and its high part starts the next word at bit 0. Whenever 32 bits have built up, a complete word is handed to the bus.

A flush request closes the current word early. Any partial word goes out with its unused top bits cleared, and the next instruction starts at bit 0 of a new word. This gives the receiver an aligned point where it can restart decoding. The output side is a valid/ready pair that holds its word until it is taken. While a finished word is waiting and the bus is not ready, the input is held off.

Control is split into two small state machines. The fill machine has two states. FILL_EMPTY holds no pending bits. FILL_PART holds between 1 and 31 pending bits. Its transitions are:
- accept-partial: FILL_EMPTY to FILL_PART.
- accept-exact: stays in FILL_EMPTY, when a 32-bit instruction is accepted.
- spill-remainder: stays in FILL_PART, when a word goes out and bits are left over.
- spill-exact: FILL_PART to FILL_EMPTY, when a word goes out and nothing is left over.
- flush-close: FILL_PART to FILL_EMPTY, when a flush sends out a partial word.

The output machine has two states. OUT_IDLE has no word. OUT_HELD has a word presented. Its transitions are:
- load: from either state into OUT_HELD.
- drain: OUT_HELD to OUT_IDLE, when the word is taken and nothing new is loaded.
- hold: stays in OUT_HELD, when the bus is not ready.

Top module: `instr_bus_packer`

## Requirements
- R1: After reset, out_valid is 0, no bits are pending, and in_ready is 1 while flush is low.
- R2: Bits fill from the least significant end. The first accepted instruction after reset or a flush occupies bit 0 upward. Each later instruction starts at the bit just above the last bit of the one before it.
- R3: An instruction that does not fit in the space left in the current word is split. Its low bits fill the top of the current word and its remaining bits continue at bit 0 of the next word. No word leaves with pending bits below 32 unless it is flushed.
- R4: A word that becomes complete on an accepting clock edge is presented on out_valid/out_data immediately after that edge.
- R5: Payload bits at positions equal to or above in_len are ignored.
- R6: An input with in_len equal to 0 or greater than 32 is ignored. No bits are added to the word.
- R7: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_data holds its value.
- R8: A flush taken while bits are pending sends one word containing those bits, with all higher bits set to 0. The next instruction then starts at bit 0. A flush with no pending bits sends nothing. in_ready is 0 in any cycle where flush is 1.
- R9: A 32-bit instruction accepted with no bits pending goes out unchanged as one word and leaves no bits pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction offered |
| in_data | input | 32 | Instruction payload, right-aligned |
| in_len | input | 6 | Payload length in bits; 1 to 32 is valid |
| in_ready | output | 1 | Instruction accepted when in_valid and in_ready are both 1 |
| flush | input | 1 | Close the current word, held until taken |
| out_valid | output | 1 | Packed word presented |
| out_data | output | 32 | Packed bus word |
| out_ready | input | 1 | Bus takes the word on this edge |

## Verification
The directed cases target the places where a packer typically loses or duplicates bits:
- **Splits:** three 22/22/20-bit instructions straddle a word boundary. A wrong split offset would shift the second word.
- **Masking and length checks:** payloads carry garbage above their length, and lengths of 0 and 40 are offered. A missing mask or length check would corrupt the upper bits of the packed word or add phantom bits.
- **Flush:** flushes are issued both on a partial word and on an empty one. The first checks that the top bits come out zero and that the next instruction restarts at bit 0. The second checks that no empty word is sent.
- **Back-pressure:** a held word must not change while the bus is not ready. A long stream with irregular lengths runs under toggling out_ready, which would expose dropped or repeated words.

// File: rtl/vlpack_pkg.sv
package vlpack_pkg;

    // Fill level of the packing accumulator
    typedef enum logic [0:0] {
        FILL_EMPTY = 1'b0,
        FILL_PART  = 1'b1
    } fill_state_t;

    // Output holding register
    typedef enum logic [0:0] {
        OUT_IDLE = 1'b0,
        OUT_HELD = 1'b1
    } out_state_t;

endpackage

// File: rtl/vlp_merge.sv
module vlp_merge #(
    parameter int BUS_W  = 32,
    parameter int LEN_W  = 6,
    parameter int ACC_W  = 64,
    parameter int FILL_W = 6
) (
    input  logic [ACC_W-1:0]  acc_q,
    input  logic [FILL_W-1:0] fill_q,
    input  logic [BUS_W-1:0]  din,
    input  logic [LEN_W-1:0]  len,
    input  logic              take,
    output logic [ACC_W-1:0]  acc_m,
    output logic [FILL_W-1:0] fill_m,
    output logic              len_ok
);

    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(BUS_W);

    logic [ACC_W-1:0] keep_mask;
    logic [ACC_W-1:0] payload;
    logic [ACC_W-1:0] placed;

    // Only lengths 1..BUS_W carry bits
    assign len_ok = (len != '0) && (len <= MAX_LEN);

    // Clear every bit at or above the declared length
    always_comb begin
        keep_mask = (ACC_W'(1) << len) - ACC_W'(1);
        payload   = ACC_W'(din) & keep_mask;
        placed    = payload << fill_q;
    end

    // Append above the pending bits
    assign acc_m  = take ? (acc_q | placed) : acc_q;
    assign fill_m = take ? (fill_q + FILL_W'(len)) : fill_q;

endmodule

// File: rtl/vlp_outreg.sv
module vlp_outreg
    import vlpack_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BUS_W-1:0] word,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [BUS_W-1:0] out_data,
    output logic             stall
);

    out_state_t       state_q, state_d;
    logic [BUS_W-1:0] data_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                data_q <= word;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_IDLE: begin
                if (load) state_d = OUT_HELD;          // load
            end
            OUT_HELD: begin
                if (load)           state_d = OUT_HELD; // load
                else if (out_ready) state_d = OUT_IDLE; // drain
                else                state_d = OUT_HELD; // hold
            end
        endcase
    end

    // Outputs
    always_comb begin
        out_valid = (state_q == OUT_HELD);
        out_data  = data_q;
        stall     = (state_q == OUT_HELD) && !out_ready;
    end

    // R7: a presented word stays put while the bus is not ready
    assert_hold_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7: nothing overwrites a word that is still waiting
    assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !load);

endmodule

// File: rtl/vlp_ctrl.sv
module vlp_ctrl
    import vlpack_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int ACC_W  = 64,
    parameter int FILL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              flush,
    input  logic              stall,
    input  logic              len_ok,
    input  logic [ACC_W-1:0]  acc_m,
    input  logic [FILL_W-1:0] fill_m,
    output logic [ACC_W-1:0]  acc_q,
    output logic [FILL_W-1:0] fill_q,
    output logic              take,
    output logic              in_ready,
    output logic              emit,
    output logic [BUS_W-1:0]  emit_word
);

    localparam logic [FILL_W-1:0] BUS_FILL = FILL_W'(BUS_W);

    fill_state_t       state_q, state_d;
    logic [ACC_W-1:0]  acc_d;
    logic [FILL_W-1:0] fill_d;

    logic              word_full;
    logic [ACC_W-1:0]  acc_spill;
    logic [FILL_W-1:0] fill_spill;

    // Handshake toward the source
    always_comb begin
        in_ready = !stall && !flush;
        take     = in_valid && in_ready && len_ok;
    end

    // What is left after a complete word is taken off the bottom
    always_comb begin
        word_full  = (fill_m >= BUS_FILL);
        acc_spill  = acc_m >> BUS_W;
        fill_spill = fill_m - BUS_FILL;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_EMPTY;
            acc_q   <= '0;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
            fill_q  <= fill_d;
        end
    end

    // Next state and outputs toward the holding register
    always_comb begin
        state_d   = state_q;
        acc_d     = acc_q;
        fill_d    = fill_q;
        emit      = 1'b0;
        emit_word = acc_q[BUS_W-1:0];
        unique case (state_q)
            FILL_EMPTY: begin
                if (take) begin
                    if (word_full) begin              // accept-exact
                        emit      = 1'b1;
                        emit_word = acc_m[BUS_W-1:0];
                        acc_d     = acc_spill;
                        fill_d    = fill_spill;
                        state_d   = FILL_EMPTY;
                    end else begin                    // accept-partial
                        acc_d   = acc_m;
                        fill_d  = fill_m;
                        state_d = FILL_PART;
                    end
                end
            end
            FILL_PART: begin
                if (!stall && flush) begin            // flush-close
                    emit      = 1'b1;
                    emit_word = acc_q[BUS_W-1:0];
                    acc_d     = '0;
                    fill_d    = '0;
                    state_d   = FILL_EMPTY;
                end else if (take) begin
                    if (word_full) begin
                        emit      = 1'b1;
                        emit_word = acc_m[BUS_W-1:0];
                        acc_d     = acc_spill;
                        fill_d    = fill_spill;
                        state_d   = (fill_spill == '0) ? FILL_EMPTY  // spill-exact
                                                       : FILL_PART;  // spill-remainder
                    end else begin
                        acc_d   = acc_m;
                        fill_d  = fill_m;
                        state_d = FILL_PART;
                    end
                end
            end
        endcase
    end

    // R3: a full word never stays behind in the accumulator
    assert_fill_below_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q < BUS_FILL);

    // R8: bits above the fill level are always clear, so a flushed word has a zero top
    assert_upper_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q >> fill_q) == '0);

    // R8: a flush that is taken leaves nothing pending
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !stall) |=> (fill_q == '0));

    // R8: no input is taken while flush is requested
    assert_flush_blocks_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !take);

    // R6: a bad length leaves the pending bits untouched
    assert_bad_len_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !len_ok && !flush) |=> ($stable(fill_q) && $stable(acc_q)));

    // R7: input is held off while the output is stalled
    assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !in_ready);

endmodule

// File: rtl/instr_bus_packer.sv
module instr_bus_packer #(
    parameter int BUS_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [BUS_W-1:0]           in_data,
    input  logic [$clog2(BUS_W):0]     in_len,
    output logic                       in_ready,
    input  logic                       flush,
    output logic                       out_valid,
    output logic [BUS_W-1:0]           out_data,
    input  logic                       out_ready
);

    localparam int LEN_W  = $clog2(BUS_W) + 1;
    localparam int ACC_W  = 2 * BUS_W;
    localparam int FILL_W = $clog2(ACC_W);

    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  acc_m;
    logic [FILL_W-1:0] fill_q;
    logic [FILL_W-1:0] fill_m;
    logic              take;
    logic              len_ok;
    logic              stall;
    logic              emit;
    logic [BUS_W-1:0]  emit_word;

    vlp_merge #(
        .BUS_W (BUS_W),
        .LEN_W (LEN_W),
        .ACC_W (ACC_W),
        .FILL_W(FILL_W)
    ) u_merge (
        .acc_q (acc_q),
        .fill_q(fill_q),
        .din   (in_data),
        .len   (in_len),
        .take  (take),
        .acc_m (acc_m),
        .fill_m(fill_m),
        .len_ok(len_ok)
    );

    vlp_ctrl #(
        .BUS_W (BUS_W),
        .ACC_W (ACC_W),
        .FILL_W(FILL_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .flush    (flush),
        .stall    (stall),
        .len_ok   (len_ok),
        .acc_m    (acc_m),
        .fill_m   (fill_m),
        .acc_q    (acc_q),
        .fill_q   (fill_q),
        .take     (take),
        .in_ready (in_ready),
        .emit     (emit),
        .emit_word(emit_word)
    );

    vlp_outreg #(
        .BUS_W(BUS_W)
    ) u_outreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (emit),
        .word     (emit_word),
        .out_ready(out_ready),
        .out_valid(out_valid),
        .out_data (out_data),
        .stall    (stall)
    );

    // R4: a word produced on an edge is presented right after it
    assert_emit_presents_R4: assert property (@(posedge clk) disable iff (!rst_n)
        emit |=> out_valid);

endmodule

// File: tb/test_instr_bus_packer.sv
`timescale 1ns/1ps
module test_instr_bus_packer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic [5:0]  in_len = '0;
    logic        in_ready;
    logic        flush = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ready = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit rdy_toggle = 1'b0;
    int rdy_cnt = 0;

    logic [31:0] got_q[$];
    logic [31:0] exp_q[$];
    logic [63:0] ref_acc = '0;
    int          ref_fill = 0;

    always #2 clk = ~clk;   // 250 MHz

    instr_bus_packer i_instr_bus_packer (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_len   (in_len),
        .in_ready (in_ready),
        .flush    (flush),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_ready(out_ready)
    );

    // Collect words taken by the bus
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) got_q.push_back(out_data);
    end

    // Optional irregular bus readiness
    always @(posedge clk) begin
        #1;
        if (rdy_toggle) begin
            rdy_cnt++;
            out_ready = ((rdy_cnt % 3) != 0) && ((rdy_cnt % 7) != 2);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected packing from the requirements
    task automatic ref_push(input logic [31:0] d, input int len);
        logic [63:0] m;
        if (len == 0 || len > 32) return;
        m = (64'd1 << len) - 64'd1;
        ref_acc  = ref_acc | ((64'(d) & m) << ref_fill);
        ref_fill = ref_fill + len;
        if (ref_fill >= 32) begin
            exp_q.push_back(ref_acc[31:0]);
            ref_acc  = ref_acc >> 32;
            ref_fill = ref_fill - 32;
        end
    endtask

    task automatic ref_flush();
        if (ref_fill > 0) exp_q.push_back(ref_acc[31:0]);
        ref_acc  = '0;
        ref_fill = 0;
    endtask

    task automatic send(input logic [31:0] d, input int len);
        in_valid = 1'b1;
        in_data  = d;
        in_len   = 6'(len);
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        ref_push(d, len);
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b0, "R8 in_ready during flush", 32'(in_ready), 32'd0);
        while (out_valid && !out_ready) @(negedge clk);
        @(posedge clk);
        #1;
        flush = 1'b0;
        ref_flush();
    endtask

    task automatic drain(input string req);
        repeat (40) @(negedge clk);
        chk(got_q.size() == exp_q.size(), {req, " word count"}, 32'(got_q.size()), 32'(exp_q.size()));
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
            chk(got_q[i] === exp_q[i], req, got_q[i], exp_q[i]);
        got_q.delete();
        exp_q.delete();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);
        do_flush();
        drain("R1 nothing pending after reset");
    endtask

    task automatic t_pack_split();
        send(32'h002A_AAAA, 22);
        send(32'h0015_5555, 22);
        send(32'h000F_0F0F, 20);
        drain("R2 R3 split across words");
        send(32'h0000_0007, 3);
        send(32'h0000_0001, 1);
        send(32'h0000_0ABC, 12);
        do_flush();
        drain("R2 consecutive placement");
    endtask

    task automatic t_mask();
        send(32'hFFFF_FF2A, 8);
        send(32'hDEAD_BEEF, 4);
        do_flush();
        drain("R5 payload above length masked");
    endtask

    task automatic t_bad_len();
        send(32'h0000_1234, 0);
        send(32'hCAFE_F00D, 40);
        send(32'h0000_0005, 4);
        do_flush();
        drain("R6 zero and oversize lengths ignored");
    endtask

    task automatic t_full_word();
        send(32'hA5A5_5A5A, 32);
        @(negedge clk);
        chk(out_valid == 1'b1, "R4 word presented after accepting edge", 32'(out_valid), 32'd1);
        chk(out_data == 32'hA5A5_5A5A, "R9 aligned 32-bit word", out_data, 32'hA5A5_5A5A);
        drain("R9 aligned word leaves nothing pending");
    endtask

    task automatic t_stall();
        logic [31:0] held;
        out_ready = 1'b0;
        send(32'h0000_BEEF, 16);
        send(32'h0000_1234, 16);
        @(negedge clk);
        chk(out_valid == 1'b1, "R7 word waiting", 32'(out_valid), 32'd1);
        chk(in_ready == 1'b0, "R7 in_ready low while stalled", 32'(in_ready), 32'd0);
        held = out_data;
        repeat (4) @(negedge clk);
        chk(out_data == held, "R7 out_data held", out_data, held);
        chk(in_ready == 1'b0, "R7 in_ready still low", 32'(in_ready), 32'd0);
        @(posedge clk);
        #1;
        out_ready = 1'b1;
        drain("R7 stalled word delivered once");
    endtask

    task automatic t_flush();
        send(32'hFFFF_FFFF, 10);
        do_flush();
        send(32'h0000_00AB, 8);
        do_flush();
        drain("R8 partial word zero-filled, restart at bit 0");
        do_flush();
        drain("R8 flush on empty sends nothing");
    endtask

    task automatic t_stream();
        logic [31:0] r = 32'h1357_9BDF;
        rdy_toggle = 1'b1;
        for (int k = 0; k < 60; k++) begin
            r = r ^ (r << 13);
            r = r ^ (r >> 17);
            r = r ^ (r << 5);
            send(r, int'(r[4:0]) + 1);
        end
        do_flush();
        rdy_toggle = 1'b0;
        @(posedge clk);
        #1;
        out_ready = 1'b1;
        drain("R3 irregular stream under back-pressure");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_pack_split();
        t_mask();
        t_bad_len();
        t_full_word();
        t_stall();
        t_flush();
        t_stream();
        finish_run();
    end

endmodule